// File: doc/BRIEF.md
# Mirrored Work RAM Window Decoder

This block serves the top quarter of a 64KB memory map of an 8-bit CPU. An internal 8K-byte work RAM answers every memory read and write whose two highest address bits are both 1. Because the RAM is half the size of that 16KB window, address bit 13 takes no part in indexing. The upper half of the window therefore reaches the same cells as the lower half.

A control byte, written through an I/O port, can switch the internal RAM off. The window is then handed to an external device through a separate select output. Four write-only bank-mapper registers occupy the last four addresses of the map. They capture writes there at all times. While the RAM is on, the same writes also land in RAM, so software can read the values back. Writes to the last eight addresses also raise a strobe for memory-mapped peripherals.

The RAM is synchronous. A write commits on the clock edge where the strobe is active. Read data appears one cycle after the read strobe, and a valid flag marks it.

Top module: `wram_window`

## Requirements
- R1: A memory access (read or write strobe) counts as a window access only when addr_i[15:14] is 2'b11. Outside the window, ram_sel_o and ext_sel_o stay low, no RAM cell changes, and rdata_valid_o stays low.
- R2: The RAM cell index is addr_i[12:0]. Bit 13 is ignored, so for example address 16'hE123 reaches the same cell as 16'hC123.
- R3: While the RAM is enabled, a window write commits on that clock edge. A window read with mem_wr_i low raises rdata_valid_o for exactly the next cycle, with the addressed cell on rdata_o. If mem_rd_i and mem_wr_i are both high, the write happens and no read data is produced.
- R4: While the RAM is disabled (control bit 4 = 1), window accesses assert ext_sel_o instead of ram_sel_o, writes leave RAM unchanged, and reads produce no rdata_valid_o.
- R5: After reset, ctrl_o is 8'h00, so the RAM is enabled. map_o is 32'h02010000, where byte i (bits 8*i+7:8*i) belongs to address 16'hFFFC+i.
- R6: An io_wr_i with addr_i[7:0] == 8'h3E latches all of wdata_i into ctrl_o on that edge. addr_i[15:8] is ignored. Writes to other port numbers change nothing. Only bit 4 gates the RAM, and 1 means disabled.
- R7: A memory write to 16'hFFFC..16'hFFFF updates byte addr_i[1:0] of map_o on that edge, whether the RAM is enabled or not. The same write is stored in RAM when enabled, so a later read there returns it. Writes to mirror addresses such as 16'hDFFC leave map_o unchanged.
- R8: periph_sel_o is high in exactly those cycles where mem_wr_i is high and addr_i is in 16'hFFF8..16'hFFFF, independent of the RAM enable.
- R9: rdata_o reads 8'h00 whenever rdata_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus (low byte is the port number for I/O) |
| wdata_i | input | 8 | CPU write data |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| io_wr_i | input | 1 | I/O write strobe |
| rdata_o | output | 8 | RAM read data, zero when not valid |
| rdata_valid_o | output | 1 | Read data valid, one cycle after the read |
| ram_sel_o | output | 1 | Internal RAM serves this access |
| ext_sel_o | output | 1 | Window released to the external device for this access |
| periph_sel_o | output | 1 | Write strobe for the top-of-map peripherals |
| ctrl_o | output | 8 | Latched control byte |
| map_o | output | 32 | Mapper register copies, byte i for address 16'hFFFC+i |

## Verification
A single write to the mapper addresses sets three things in one cycle: the mapper byte, the mirrored RAM cell and the peripheral strobe. The bench issues such writes with the RAM enabled and with it disabled. It checks the strobe in the same cycle and map_o after the edge. It then reads the address back, and also reads its lower mirror, and the scoreboard judges each read against a model that stores the byte only while the RAM was enabled.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef struct packed {
    logic ram_hit;
    logic ext_hit;
    logic periph;
    logic map_hit;
  } wram_dec_t;
endpackage

// File: rtl/wram_decode.sv
module wram_decode
  import wram_pkg::*;
#(
  parameter int AW        = 16,
  parameter int N_MAP     = 4,
  parameter int PERI_LOG2 = 3,
  localparam int MAP_LOG2 = $clog2(N_MAP)
) (
  input  logic [AW-1:0]       addr_i,
  input  logic                mem_rd_i,
  input  logic                mem_wr_i,
  input  logic                ram_on_i,
  output wram_dec_t           dec_o,
  output logic [MAP_LOG2-1:0] map_idx_o
);
  logic in_win, access;

  assign in_win = &addr_i[AW-1:AW-2];
  assign access = mem_rd_i | mem_wr_i;

  always_comb begin
    dec_o.ram_hit = in_win & access & ram_on_i;
    dec_o.ext_hit = in_win & access & ~ram_on_i;
    dec_o.periph  = mem_wr_i & (&addr_i[AW-1:PERI_LOG2]);
    dec_o.map_hit = mem_wr_i & (&addr_i[AW-1:MAP_LOG2]);
  end

  assign map_idx_o = addr_i[MAP_LOG2-1:0];
endmodule

// File: rtl/wram_regs.sv
module wram_regs #(
  parameter int              DW        = 8,
  parameter int              N_MAP     = 4,
  parameter logic [7:0]      CTRL_PORT = 8'h3E,
  parameter int              EN_BIT    = 4,
  parameter logic [N_MAP*DW-1:0] MAP_RST = 32'h0201_0000,
  localparam int             MAP_LOG2  = $clog2(N_MAP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          port_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                io_wr_i,
  input  logic                map_we_i,
  input  logic [MAP_LOG2-1:0] map_idx_i,
  output logic [DW-1:0]       ctrl_o,
  output logic                ram_on_o,
  output logic [N_MAP*DW-1:0] map_o
);
  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= '0;
    else if (io_wr_i && port_i == CTRL_PORT)  ctrl_q <= wdata_i;
  end

  assign ctrl_o   = ctrl_q;
  assign ram_on_o = ~ctrl_q[EN_BIT];

  for (genvar i = 0; i < N_MAP; i++) begin : g_map
    logic [DW-1:0] map_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       map_q <= MAP_RST[i*DW +: DW];
      else if (map_we_i && map_idx_i == MAP_LOG2'(i))    map_q <= wdata_i;
    end
    assign map_o[i*DW +: DW] = map_q;
  end
endmodule

// File: rtl/wram_array.sv
module wram_array #(
  parameter int DW = 8,
  parameter int AW = 13,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] q_o,
  output logic          valid_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
    if (re_i) q_q <= mem[idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= re_i;
  end

  assign q_o = valid_o ? q_q : '0;
endmodule

// File: rtl/wram_window.sv
module wram_window
  import wram_pkg::*;
#(
  parameter int         AW        = 16,
  parameter int         DW        = 8,
  parameter int         RAM_AW    = 13,
  parameter int         N_MAP     = 4,
  parameter int         PERI_LOG2 = 3,
  parameter logic [7:0] CTRL_PORT = 8'h3E,
  parameter int         EN_BIT    = 4,
  parameter logic [N_MAP*DW-1:0] MAP_RST = 32'h0201_0000,
  localparam int        MAP_LOG2  = $clog2(N_MAP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                mem_rd_i,
  input  logic                mem_wr_i,
  input  logic                io_wr_i,
  output logic [DW-1:0]       rdata_o,
  output logic                rdata_valid_o,
  output logic                ram_sel_o,
  output logic                ext_sel_o,
  output logic                periph_sel_o,
  output logic [DW-1:0]       ctrl_o,
  output logic [N_MAP*DW-1:0] map_o
);
  wram_dec_t           dec;
  logic [MAP_LOG2-1:0] map_idx;
  logic                ram_on;

  wram_decode #(.AW(AW), .N_MAP(N_MAP), .PERI_LOG2(PERI_LOG2)) u_dec (
    .addr_i    (addr_i),
    .mem_rd_i  (mem_rd_i),
    .mem_wr_i  (mem_wr_i),
    .ram_on_i  (ram_on),
    .dec_o     (dec),
    .map_idx_o (map_idx)
  );

  wram_regs #(
    .DW(DW), .N_MAP(N_MAP), .CTRL_PORT(CTRL_PORT), .EN_BIT(EN_BIT), .MAP_RST(MAP_RST)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_i    (addr_i[7:0]),
    .wdata_i   (wdata_i),
    .io_wr_i   (io_wr_i),
    .map_we_i  (dec.map_hit),
    .map_idx_i (map_idx),
    .ctrl_o    (ctrl_o),
    .ram_on_o  (ram_on),
    .map_o     (map_o)
  );

  // bit 13 dropped: the upper window half mirrors the lower one
  wram_array #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (addr_i[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .we_i    (dec.ram_hit & mem_wr_i),
    .re_i    (dec.ram_hit & mem_rd_i & ~mem_wr_i),
    .q_o     (rdata_o),
    .valid_o (rdata_valid_o)
  );

  assign ram_sel_o    = dec.ram_hit;
  assign ext_sel_o    = dec.ext_hit;
  assign periph_sel_o = dec.periph;
endmodule

// File: rtl/wram_window_chk.sv
module wram_window_chk #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int N_MAP = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic                mem_rd_i,
  input logic                mem_wr_i,
  input logic [DW-1:0]       rdata_o,
  input logic                rdata_valid_o,
  input logic                ram_sel_o,
  input logic                ext_sel_o,
  input logic                periph_sel_o,
  input logic [N_MAP*DW-1:0] map_o
);
  AST_NO_SEL_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&addr_i[AW-1:AW-2]) |-> !ram_sel_o && !ext_sel_o); // R1

  AST_READ_GIVES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_sel_o && mem_rd_i && !mem_wr_i) |=> rdata_valid_o); // R3

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_sel_o || mem_wr_i) |=> !rdata_valid_o); // R3

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_sel_o && ext_sel_o)); // R4

  AST_PERIPH_TOP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_sel_o |-> mem_wr_i && (&addr_i[AW-1:3])); // R8

  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_i && (&addr_i[AW-1:2])) |=> $stable(map_o)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_valid_o |-> rdata_o == '0); // R9
endmodule

bind wram_window wram_window_chk #(.AW(AW), .DW(DW), .N_MAP(N_MAP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .mem_rd_i      (mem_rd_i),
  .mem_wr_i      (mem_wr_i),
  .rdata_o       (rdata_o),
  .rdata_valid_o (rdata_valid_o),
  .ram_sel_o     (ram_sel_o),
  .ext_sel_o     (ext_sel_o),
  .periph_sel_o  (periph_sel_o),
  .map_o         (map_o)
);

// File: tb/wram_window_bench.sv
module wram_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_wr = 1'b0;
  logic [7:0]  rdata, ctrl;
  logic        rvalid, ram_sel, ext_sel, periph_sel;
  logic [31:0] map;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0]  mdl [8192];
  logic [7:0]  mmap [4];
  logic [7:0]  mctrl;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  wram_window u_wram_window (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .io_wr_i(io_wr),
    .rdata_o(rdata), .rdata_valid_o(rvalid), .ram_sel_o(ram_sel),
    .ext_sel_o(ext_sel), .periph_sel_o(periph_sel), .ctrl_o(ctrl), .map_o(map)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, checks decode outputs, updates the model
  task automatic op(input bit rd, input bit wr, input bit io, input logic [15:0] a,
                    input logic [7:0] d, input string tag);
    bit win, en, acc;
    @(negedge clk);
    addr = a; wdata = d; mem_rd = rd; mem_wr = wr; io_wr = io;
    #2;
    win = a[15:14] == 2'b11;
    en  = !mctrl[4];
    acc = rd | wr;
    chk({ram_sel, ext_sel, periph_sel} ==
        {win & acc & en, win & acc & !en, wr & (a[15:3] == 13'h1FFF)},
        tag, {ram_sel, ext_sel, periph_sel},
        {win & acc & en, win & acc & !en, wr & (a[15:3] == 13'h1FFF)});
    if (rd && !wr && win && en) begin
      exp_q.push_back(mdl[a[12:0]]);
      tag_q.push_back(tag);
    end
    if (wr && win && en) mdl[a[12:0]] = d;
    if (wr && a[15:2] == 14'h3FFF) mmap[a[1:0]] = d;
    if (io && a[7:0] == 8'h3E) mctrl = d;
  endtask

  task automatic idle();
    @(negedge clk);
    mem_rd = 1'b0; mem_wr = 1'b0; io_wr = 1'b0;
  endtask

  task automatic chk_regs(input string tag);
    @(negedge clk);
    chk(map == {mmap[3], mmap[2], mmap[1], mmap[0]}, tag, map, {mmap[3], mmap[2], mmap[1], mmap[0]});
    chk(ctrl == mctrl, tag, {24'h0, ctrl}, {24'h0, mctrl});
  endtask

  // monitor: pops expected read data as valid data appears
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rvalid) begin
        if (exp_q.size() == 0) chk(1'b0, "R3/R4 unexpected rdata_valid", {24'h0, rdata}, 32'h0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata == e, t, {24'h0, rdata}, {24'h0, e});
        end
      end else if (rdata != 8'h00) chk(1'b0, "R9 rdata not zero while idle", {24'h0, rdata}, 32'h0);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    mmap[0] = 8'h00; mmap[1] = 8'h00; mmap[2] = 8'h01; mmap[3] = 8'h02;
    mctrl = 8'h00;
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0, "R5 valid low in reset", {31'h0, rvalid}, 32'h0);
    chk(map == 32'h0201_0000, "R5 mapper reset", map, 32'h0201_0000);
    chk(ctrl == 8'h00, "R5 control reset", {24'h0, ctrl}, 32'h0);
    rst_n = 1'b1;

    // R3 basic write then read
    op(0, 1, 0, 16'hC000, 8'h11, "R3 wr");
    op(0, 1, 0, 16'hC123, 8'h5A, "R3 wr");
    op(0, 1, 0, 16'hDFFF, 8'hA5, "R3 wr");
    op(0, 1, 0, 16'hDFFE, 8'h66, "R3 wr");
    op(1, 0, 0, 16'hC000, 8'h00, "R3 rd C000");
    op(1, 0, 0, 16'hC123, 8'h00, "R3 rd C123");
    op(1, 0, 0, 16'hDFFF, 8'h00, "R3 rd DFFF");
    // R2 mirror
    op(1, 0, 0, 16'hE123, 8'h00, "R2 rd E123 mirror");
    op(0, 1, 0, 16'hF456, 8'h77, "R2 wr F456");
    op(1, 0, 0, 16'hD456, 8'h00, "R2 rd D456 mirror");
    // R1 outside the window
    op(0, 1, 0, 16'h8000, 8'h99, "R1 wr outside");
    op(1, 0, 0, 16'h8000, 8'h00, "R1 rd outside");
    op(1, 0, 0, 16'hBFFF, 8'h00, "R1 rd BFFF");
    op(1, 0, 0, 16'h0123, 8'h00, "R1 rd low");
    op(1, 0, 0, 16'hC000, 8'h00, "R1 cell untouched");
    // R3 read and write together: write wins, no data
    op(1, 1, 0, 16'hC200, 8'h3C, "R3 rd+wr");
    op(1, 0, 0, 16'hC200, 8'h00, "R3 rd after rd+wr");
    // R7 / R8 mapper writes, enabled
    op(0, 1, 0, 16'hFFFD, 8'h05, "R7 wr FFFD");
    op(0, 1, 0, 16'hFFF9, 8'h3C, "R8 wr FFF9");
    op(0, 1, 0, 16'hDFFC, 8'h44, "R7 wr DFFC mirror");
    op(0, 1, 0, 16'hFFF7, 8'h21, "R8 wr FFF7");
    idle();
    chk_regs("R7 mapper after writes");
    op(1, 0, 0, 16'hFFFD, 8'h00, "R7 rd FFFD");
    op(1, 0, 0, 16'hDFFD, 8'h00, "R7 rd DFFD");
    op(1, 0, 0, 16'hFFF9, 8'h00, "R8 rd FFF9");
    op(1, 0, 0, 16'hFFFC, 8'h00, "R7 rd FFFC");
    // R6 port decode
    op(0, 0, 1, 16'h003F, 8'h10, "R6 io other port");
    idle();
    chk_regs("R6 other port ignored");
    op(1, 0, 0, 16'hC000, 8'h00, "R6 rd still enabled");
    op(0, 0, 1, 16'h123E, 8'hEF, "R6 io 3E bit4 clear");
    idle();
    chk_regs("R6 latch all bits");
    op(1, 0, 0, 16'hC123, 8'h00, "R6 rd enabled bit4 clear");
    // R4 disabled
    op(0, 0, 1, 16'h003E, 8'h10, "R4 io disable");
    op(0, 1, 0, 16'hC000, 8'hEE, "R4 wr blocked");
    op(1, 0, 0, 16'hC000, 8'h00, "R4 rd blocked");
    op(0, 1, 0, 16'hFFFE, 8'h09, "R7 wr FFFE disabled");
    op(0, 1, 0, 16'h7000, 8'h01, "R1 outside while disabled");
    idle();
    chk_regs("R7 mapper while disabled");
    op(0, 0, 1, 16'h003E, 8'h00, "R4 io enable");
    op(1, 0, 0, 16'hC000, 8'h00, "R4 rd after re-enable");
    op(1, 0, 0, 16'hFFFE, 8'h00, "R7 rd FFFE kept old cell");
    op(0, 1, 0, 16'hFFFF, 8'h7E, "R7 wr FFFF");
    op(1, 0, 0, 16'hDFFF, 8'h00, "R7 rd DFFF");
    idle();
    chk_regs("R7 final mapper");
    repeat (3) idle();
    chk(exp_q.size() == 0, "R3 missing read data", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule